// File: doc/BRIEF.md
# SMI Event Status Aggregator

This block gathers the sources that may raise a system-management interrupt into one 16-bit status word and drives a single active-low request line. Four sources are strobes: a software timer expiry, a write to the APM control port, a write to the sleep-enable control, and a write to the global-release control. Each strobe, gated by its own qualifying enable, latches a sticky status bit. Software clears a sticky bit by writing 1 to its position. Three further status bits are live, read-only summaries:

- the power-management status bits ANDed with their enables;
- the legacy-USB status bits ANDed with their enables;
- the general-purpose inputs that are enabled, routed to SMI and present on the part.

Software reaches the block through a write-only port with one select bit. Select 0 addresses the status word, where writes clear bits. Select 1 addresses the GPI SMI enable register. The status word and the enable register are always visible as outputs. The request is registered, so it follows the status word one clock later.

Top module: `smi_event_agg`

## Requirements
- R1: After reset the status word is 0000h, the GPI enable register is 0000h, and `smi_n_o` is 1.
- R2: A timer-expiry strobe sets status bit 4 on the next clock. The bit stays 1 until a status write (select 0) carries 1 in bit 4. A status write with 0 in bit 4 leaves it unchanged.
- R3: An APM-port strobe sets status bit 3 only when the APM enable input is 1 during that clock. Otherwise the strobe has no effect. The bit is cleared by writing 1 to bit 3.
- R4: A sleep-enable strobe sets status bit 2 only when the sleep-SMI enable input is 1 during that clock. The bit is cleared by writing 1 to bit 2.
- R5: A global-release strobe sets status bit 0. This bit asks for an SMI only while the BIOS enable input is also 1. It is cleared by writing 1 to bit 0.
- R6: Status bit 1 is read-only. It equals the OR over i of (usb_sts[i] AND usb_en[i]), so it reads 0 when no enable is set.
- R7: Status bit 5 is read-only. It equals the OR over i of (pm_sts[i] AND pm_en[i]).
- R8: A write with select 1 loads the GPI enable register from the write data. Bits of GPIOs that are absent from the parameter `GPI_IMPL` always read 0. A write with select 0 leaves this register unchanged.
- R9: Status bit 6 is read-only. It is 1 when any GPI n has all of the following at 1: its input level, its enable bit, its SMI routing input, and bit n of `GPI_IMPL`.
- R10: `smi_n_o` is 0 in the cycle after a cycle in which any of these holds: status bits 1 to 6 are nonzero, or status bit 0 and the BIOS enable are both 1. Otherwise `smi_n_o` is 1 in that following cycle.
- R11: When a set strobe and a write-1-clear reach the same sticky bit in the same clock, the bit ends up 1.
- R12: Status bits 15 to 7 always read 0. Writing 1 to a read-only or reserved status position changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_expire_i | input | 1 | Software SMI timer expiry strobe |
| apm_wr_i | input | 1 | APM control port write strobe |
| apm_en_i | input | 1 | APM SMI enable |
| slp_wr_i | input | 1 | Strobe for a write of 1 to the sleep-enable control |
| slp_smi_en_i | input | 1 | Sleep SMI enable |
| gbl_rls_i | input | 1 | Strobe for a write of 1 to the global-release control |
| bios_en_i | input | 1 | Lets status bit 0 request an SMI |
| pm_sts_i | input | PM_W | Power-management status bits |
| pm_en_i | input | PM_W | Power-management SMI enables |
| usb_sts_i | input | USB_W | Legacy-USB status bits |
| usb_en_i | input | USB_W | Legacy-USB SMI enables |
| gpi_lvl_i | input | GPI_N | General-purpose input status levels |
| gpi_route_smi_i | input | GPI_N | 1 = this GPI is routed to SMI |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = status word (write 1 to clear), 1 = GPI enable register |
| wr_data_i | input | 16 | Write data |
| status_o | output | 16 | Status word |
| gpi_en_o | output | GPI_N | GPI SMI enable register |
| smi_n_o | output | 1 | Active-low SMI request |

## Verification
A sticky bit that is lost or stuck shows up in `status_o` at the negative edge that follows the clock on which it should have changed. It also shows up in `smi_n_o` one clock after that. An enable register that keeps an absent GPIO bit is visible on `gpi_en_o` right after the write. A gating error in a summary is visible on `status_o` within the same cycle, because the bench sweeps every status and enable combination of the USB and PM vectors. It also sweeps every enable, routing and level combination of each GPI. The priority between a set and a clear is tested by driving both on the same edge.

// File: rtl/smi_agg_pkg.sv
// Shared constants for the SMI event status aggregator.
// Assumes a 16-bit status word. The bit positions are fixed because software decodes them.
package smi_agg_pkg;
    localparam int STS_W    = 16;
    localparam int B_BIOS   = 0;
    localparam int B_USB    = 1;
    localparam int B_SLP    = 2;
    localparam int B_APM    = 3;
    localparam int B_TMR    = 4;
    localparam int B_PM     = 5;
    localparam int B_GPI    = 6;
    localparam int N_STICKY = 4;

    typedef enum logic {SEL_STS = 1'b0, SEL_GPIEN = 1'b1} wr_sel_e;

    // Maps sticky cell index to its position in the status word
    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return B_BIOS;
            1:       return B_SLP;
            2:       return B_APM;
            default: return B_TMR;
        endcase
    endfunction
endpackage

// File: rtl/smi_sticky_bit.sv
// One sticky status cell: a set pulse latches 1, a clear pulse drops it to 0.
// When both arrive in the same clock, set has priority. Synchronous active-low reset.
module smi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the status bit with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/smi_gpi_gate.sv
// GPI SMI enable register with qualification by the implemented-GPIO mask.
// Produces the summary hit of all qualifying GPIs.
// Assumes GPI_N <= 16. Bits absent from IMPL never hold 1.
module smi_gpi_gate #(
    parameter int              GPI_N = 16,
    parameter logic [GPI_N-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GPI_N-1:0] load_data_i,
    input  logic [GPI_N-1:0] lvl_i,
    input  logic [GPI_N-1:0] route_i,
    output logic [GPI_N-1:0] en_o,
    output logic             hit_o
);
    logic [GPI_N-1:0] qual;

    // Load the enable register and force absent GPIO bits to 0
    always_ff @(posedge clk) begin
        if (!rst_n)      en_o <= '0;
        else if (load_i) en_o <= load_data_i & IMPL;
    end

    // Per-GPI qualification: level, enable, routing and presence
    for (genvar g = 0; g < GPI_N; g++) begin : g_qual
        assign qual[g] = lvl_i[g] & en_o[g] & route_i[g] & IMPL[g];
    end

    assign hit_o = |qual;
endmodule

// File: rtl/smi_req_gen.sv
// Registered active-low SMI request built from the status word.
// Bit 0 counts only while the BIOS enable is set. Every other nonzero bit counts directly.
module smi_req_gen
    import smi_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] status_i,
    input  logic             bios_en_i,
    output logic             smi_n_o
);
    logic [STS_W-1:0] others;
    logic             want;

    // Mask out bit 0, which has its own gate
    always_comb begin
        others         = status_i;
        others[B_BIOS] = 1'b0;
        want           = (|others) | (status_i[B_BIOS] & bios_en_i);
    end

    // Register the request so it follows the status word by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) smi_n_o <= 1'b1;
        else        smi_n_o <= ~want;
    end
endmodule

// File: rtl/smi_event_agg.sv
// SMI event status aggregator top.
// Holds four sticky write-1-clear bits that event strobes set. Builds three read-only
// summary bits from the PM, legacy-USB and GPI sources, and drives a registered
// active-low SMI request. The write port has no handshake. Strobes last one clock.
module smi_event_agg
    import smi_agg_pkg::*;
#(
    parameter int               PM_W     = 4,
    parameter int               USB_W    = 4,
    parameter int               GPI_N    = 16,
    parameter logic [GPI_N-1:0] GPI_IMPL = 16'hBFFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_expire_i,
    input  logic             apm_wr_i,
    input  logic             apm_en_i,
    input  logic             slp_wr_i,
    input  logic             slp_smi_en_i,
    input  logic             gbl_rls_i,
    input  logic             bios_en_i,
    input  logic [PM_W-1:0]  pm_sts_i,
    input  logic [PM_W-1:0]  pm_en_i,
    input  logic [USB_W-1:0] usb_sts_i,
    input  logic [USB_W-1:0] usb_en_i,
    input  logic [GPI_N-1:0] gpi_lvl_i,
    input  logic [GPI_N-1:0] gpi_route_smi_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [15:0]      wr_data_i,
    output logic [15:0]      status_o,
    output logic [GPI_N-1:0] gpi_en_o,
    output logic             smi_n_o
);
    logic [N_STICKY-1:0] set_v;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] sticky_q;
    logic                sts_wr;
    logic                gpi_hit;

    assign sts_wr = wr_en_i & (wr_sel_i == SEL_STS);

    // Per-source set conditions, in sticky-cell index order
    always_comb begin
        set_v[0] = gbl_rls_i;
        set_v[1] = slp_wr_i & slp_smi_en_i;
        set_v[2] = apm_wr_i & apm_en_i;
        set_v[3] = tmr_expire_i;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        localparam int POS = sticky_pos(g);
        assign clr_v[g] = sts_wr & wr_data_i[POS];
        smi_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (sticky_q[g])
        );
    end

    smi_gpi_gate #(.GPI_N(GPI_N), .IMPL(GPI_IMPL)) u_gpi (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (wr_en_i & (wr_sel_i == SEL_GPIEN)),
        .load_data_i (wr_data_i[GPI_N-1:0]),
        .lvl_i       (gpi_lvl_i),
        .route_i     (gpi_route_smi_i),
        .en_o        (gpi_en_o),
        .hit_o       (gpi_hit)
    );

    // Assemble the status word. Reserved positions stay 0.
    always_comb begin
        status_o = '0;
        for (int i = 0; i < N_STICKY; i++) status_o[sticky_pos(i)] = sticky_q[i];
        status_o[B_USB] = |(usb_sts_i & usb_en_i);
        status_o[B_PM]  = |(pm_sts_i & pm_en_i);
        status_o[B_GPI] = gpi_hit;
    end

    smi_req_gen u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_o),
        .bios_en_i (bios_en_i),
        .smi_n_o   (smi_n_o)
    );
endmodule

// File: rtl/smi_event_agg_chk.sv
// Assertion checker for smi_event_agg. It is attached to the top module by the bind below.
module smi_event_agg_chk #(
    parameter int               GPI_N    = 16,
    parameter logic [GPI_N-1:0] GPI_IMPL = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_expire_i,
    input logic             gbl_rls_i,
    input logic             bios_en_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [15:0]      wr_data_i,
    input logic [15:0]      status_o,
    input logic [GPI_N-1:0] gpi_en_o,
    input logic             smi_n_o
);
    logic contrib;
    assign contrib = (|status_o[15:1]) | (status_o[0] & bios_en_i);

    // R10: a contributing status bit drives the request low on the next clock
    p_req_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        contrib |=> !smi_n_o);
    // R10: with no contributor the request is high on the next clock
    p_req_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !contrib |=> smi_n_o);
    // R2 and R11: a timer strobe always leaves bit 4 set, even when a clear arrives with it
    p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire_i |=> status_o[4]);
    // R2: bit 4 is held unless a write-1-clear reaches it
    p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] && !(wr_en_i && !wr_sel_i && wr_data_i[4])) |=> status_o[4]);
    // R5: a global-release strobe sets bit 0
    p_bios_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_rls_i |=> status_o[0]);
    // R8: bits of absent GPIOs never appear in the enable register
    p_gpi_impl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gpi_en_o & ~GPI_IMPL) == '0);
    // R12: reserved status positions stay 0
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[15:7] == 9'd0);
endmodule

bind smi_event_agg smi_event_agg_chk #(.GPI_N(GPI_N), .GPI_IMPL(GPI_IMPL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_expire_i (tmr_expire_i),
    .gbl_rls_i    (gbl_rls_i),
    .bios_en_i    (bios_en_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .status_o     (status_o),
    .gpi_en_o     (gpi_en_o),
    .smi_n_o      (smi_n_o)
);

// File: tb/smi_event_agg_test.sv
`timescale 1ns/1ps
// Self-checking bench. Inputs are driven at the negative edge, and outputs are
// sampled at the negative edge that follows each rising edge.
module smi_event_agg_test;
    localparam logic [15:0] IMPL = 16'hBFFD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_expire_i = 0, apm_wr_i = 0, apm_en_i = 0, slp_wr_i = 0;
    logic        slp_smi_en_i = 0, gbl_rls_i = 0, bios_en_i = 0;
    logic [3:0]  pm_sts_i = 0, pm_en_i = 0, usb_sts_i = 0, usb_en_i = 0;
    logic [15:0] gpi_lvl_i = 0, gpi_route_smi_i = 0;
    logic        wr_en_i = 0, wr_sel_i = 0;
    logic [15:0] wr_data_i = 0;
    logic [15:0] status_o, gpi_en_o;
    logic        smi_n_o;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    smi_event_agg #(.PM_W(4), .USB_W(4), .GPI_N(16), .GPI_IMPL(IMPL)) uut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
        step();
        wr_en_i = 0; wr_data_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        check("R1 status", status_o, 0);
        check("R1 gpi_en", gpi_en_o, 0);
        check("R1 smi_n", smi_n_o, 1);
        rst_n = 1;
        step();

        // R2: timer sticky bit, writing 0 does not clear it
        tmr_expire_i = 1; step(); tmr_expire_i = 0;
        check("R2 timer set", status_o, 16'h0010);
        step();
        check("R10 smi low", smi_n_o, 0);
        wr(0, 16'h0000);
        check("R2 write 0 keeps", status_o, 16'h0010);
        wr(0, 16'h0010);
        check("R2 cleared", status_o, 0);
        check("R10 smi lag", smi_n_o, 0);
        step();
        check("R10 smi release", smi_n_o, 1);

        // R3: APM gated by its enable
        apm_wr_i = 1; step(); apm_wr_i = 0;
        check("R3 no enable", status_o, 0);
        apm_en_i = 1; apm_wr_i = 1; step(); apm_wr_i = 0; apm_en_i = 0;
        check("R3 set", status_o, 16'h0008);
        wr(0, 16'h0008);
        check("R3 cleared", status_o, 0);

        // R4: sleep gated by its enable
        slp_wr_i = 1; step(); slp_wr_i = 0;
        check("R4 no enable", status_o, 0);
        slp_smi_en_i = 1; slp_wr_i = 1; step(); slp_wr_i = 0; slp_smi_en_i = 0;
        check("R4 set", status_o, 16'h0004);
        wr(0, 16'h0004);
        check("R4 cleared", status_o, 0);
        step();

        // R5: global release, request only with BIOS enable
        gbl_rls_i = 1; step(); gbl_rls_i = 0;
        check("R5 set", status_o, 16'h0001);
        step(); step();
        check("R5 no request without enable", smi_n_o, 1);
        bios_en_i = 1; step();
        check("R5 request with enable", smi_n_o, 0);
        wr(0, 16'h0001);
        check("R5 cleared", status_o, 0);
        bios_en_i = 0; step();
        check("R5 request released", smi_n_o, 1);

        // R11: set and clear in the same clock, set wins
        tmr_expire_i = 1; wr(0, 16'h0010); tmr_expire_i = 0;
        check("R11 set wins", status_o, 16'h0010);
        wr(0, 16'h0010);
        check("R11 later clear", status_o, 0);

        // R12: reserved and read-only positions ignore writes
        wr(0, 16'hFFFF);
        check("R12 all ones write", status_o, 0);
        usb_sts_i = 4'h1; usb_en_i = 4'h1;
        wr(0, 16'h0002);
        check("R12 RO bit survives write", status_o, 16'h0002);
        usb_sts_i = 0; usb_en_i = 0; step(); step();

        // R6 and R10: exhaustive legacy-USB sweep
        for (int c = 0; c < 256; c++) begin
            logic e;
            usb_sts_i = c[3:0]; usb_en_i = c[7:4];
            e = |(c[3:0] & c[7:4]);
            step();
            check("R6 usb summary", status_o, {15'd0, e, 1'b0});
            step();
            check("R10 usb request", smi_n_o, !e);
        end
        usb_sts_i = 0; usb_en_i = 0;

        // R7: exhaustive PM sweep
        for (int c = 0; c < 256; c++) begin
            logic e;
            pm_sts_i = c[3:0]; pm_en_i = c[7:4];
            e = |(c[3:0] & c[7:4]);
            step();
            check("R7 pm summary", status_o, {10'd0, e, 5'd0});
        end
        pm_sts_i = 0; pm_en_i = 0;

        // R8: enable register load and masking
        wr(1, 16'hFFFF);
        check("R8 masked load", gpi_en_o, IMPL);
        wr(0, 16'hFFFF);
        check("R8 status write leaves enables", gpi_en_o, IMPL);
        wr(1, 16'h0000);
        check("R8 cleared", gpi_en_o, 0);

        // R9: per-GPI sweep over enable, routing and level
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 8; c++) begin
                logic e;
                wr(1, c[0] ? (16'h1 << i) : 16'h0);
                gpi_route_smi_i = c[1] ? (16'h1 << i) : 16'h0;
                gpi_lvl_i       = c[2] ? (16'h1 << i) : 16'h0;
                e = c[0] & c[1] & c[2] & IMPL[i];
                step();
                check("R9 gpi summary", status_o, {9'd0, e, 6'd0});
            end
        end
        gpi_lvl_i = 0; gpi_route_smi_i = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule